// File: doc/BRIEF.md
# Phase-Frequency Detector with Three-State Drive and Lock Flag

This block compares two pulse trains inside a synchronous clock domain: one from the reference divider and one from the feedback divider of a frequency synthesizer. From the timing gap between their rising edges it produces the controls for a single three-state charge-pump pad. The pad is driven high, driven low, or left floating. The time spent driven equals the phase error, measured in system clocks. Because a missing edge on one side keeps the pad driven, the detector also pulls the loop toward the correct frequency.

A polarity input exchanges the two comparison inputs. This reverses the sense of the pad drive, so the same block can serve loop filters and oscillators with either tuning slope. A lock flag rises after several consecutive comparisons whose error pulse is narrow. It drops as soon as one error pulse grows wide.

Top module: `pfd_top`

## Requirements
- R1: While `rstN` is low, and on the first clock after it is released with both inputs low, `padDriveHigh`, `padDriveLow` and `lockFlag` are all 0.
- R2: An edge is a 0-to-1 change of `refIn` or `fbIn` between two consecutive clock samples. An input held high produces only one edge.
- R3: With `polSwap` = 0, if a `refIn` edge leads the `fbIn` edge by d > 0 clocks, `padDriveHigh` is 1 for exactly d clocks, starting on the clock after the `refIn` edge is sampled, and `padDriveLow` stays 0.
- R4: With `polSwap` = 0, if an `fbIn` edge leads by d > 0 clocks, `padDriveLow` is 1 for exactly d clocks and `padDriveHigh` stays 0.
- R5: With `polSwap` = 1, the roles of the inputs are exchanged. A `refIn` lead of d gives d clocks of `padDriveLow`, and an `fbIn` lead of d gives d clocks of `padDriveHigh`.
- R6: Edges that arrive on the same clock produce no drive on either output. Once both internal states are set, both are cleared on the next clock.
- R7: `padDriveHigh` and `padDriveLow` are never 1 together. The pad floats whenever both are 0.
- R8: If the leading input keeps producing edges while the other input produces none, the same drive output stays at 1 continuously until the lagging edge arrives.
- R9: `lockFlag` becomes 1 once LOCK_PERIODS (default 4) consecutive comparisons each had an error pulse of at most NARROW_MAX (default 1) clocks. It stays 0 before that.
- R10: A locked `lockFlag` falls on the clock edge where an error pulse reaches NARROW_MAX+1 clocks. With the defaults, it falls 2 clocks after the leading edge is sampled, while the pulse is still in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| refIn | input | 1 | Reference-divider pulse train |
| fbIn | input | 1 | Feedback-divider pulse train |
| polSwap | input | 1 | 1 exchanges the roles of refIn and fbIn |
| padDriveHigh | output | 1 | Enable to drive the pad high |
| padDriveLow | output | 1 | Enable to drive the pad low |
| lockFlag | output | 1 | 1 while the loop is judged locked |

## Verification
A stuck or late-clearing up or down state shows at the pads at once. The drive pulse becomes longer than the edge gap, or the wrong enable rises, on the clock after the leading edge. The bench therefore sweeps the edge gap across both signs and both polarities and counts the drive clocks exactly. A wrong lock count or a wrong width threshold only appears at `lockFlag` after several comparison periods. For that reason the lock sequence is checked on every period, and the lock drop is checked on the exact clock.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clrPair;    // both states set: clear both, end the comparison
    logic holdWidth;  // keep the width counter (unused bit reserved as 0 when clearing)
  } pfdStrobe_t;

  // State reported by the datapath
  typedef struct packed {
    logic upSet;
    logic dnSet;
  } pfdState_t;
endpackage

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_pkg::*;
#(
  parameter int NARROW_MAX = 1,
  localparam int WW = $clog2(NARROW_MAX + 2)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          refIn,
  input  logic          fbIn,
  input  logic          polSwap,
  input  pfdStrobe_t    strobe,
  output pfdState_t     state,
  output logic [WW-1:0] errWidth,
  output logic          driveHigh,
  output logic          driveLow
);
  localparam logic [WW-1:0] WIDTH_SAT = WW'(NARROW_MAX + 1);

  logic refPrev, fbPrev;
  logic refEdge, fbEdge;
  logic aEdge, bEdge;
  logic upQ, dnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPrev <= 1'b0;
      fbPrev  <= 1'b0;
    end else begin
      refPrev <= refIn;
      fbPrev  <= fbIn;
    end
  end

  assign refEdge = refIn & ~refPrev;
  assign fbEdge  = fbIn & ~fbPrev;

  // Polarity select exchanges which input sets the "up" state
  assign aEdge = polSwap ? fbEdge : refEdge;
  assign bEdge = polSwap ? refEdge : fbEdge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else begin
      upQ <= (upQ & ~strobe.clrPair) | aEdge;
      dnQ <= (dnQ & ~strobe.clrPair) | bEdge;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errWidth <= '0;
    end else if (strobe.clrPair) begin
      errWidth <= '0;
    end else if ((upQ ^ dnQ) && !strobe.holdWidth && errWidth != WIDTH_SAT) begin
      errWidth <= errWidth + 1'b1;
    end
  end

  assign state.upSet = upQ;
  assign state.dnSet = dnQ;
  assign driveHigh   = upQ & ~dnQ;
  assign driveLow    = dnQ & ~upQ;

  a_r2_up_from_edge: assert property (@(posedge clk) disable iff (!rstN)
    (!upQ && aEdge) |=> upQ);
  a_r6_pair_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (upQ && dnQ && !aEdge && !bEdge) |=> (!upQ && !dnQ));
  a_r8_drive_held: assert property (@(posedge clk) disable iff (!rstN)
    (upQ && !dnQ && !bEdge) |=> (upQ && !dnQ));
endmodule

// File: rtl/pfd_control.sv
module pfd_control
  import pfd_pkg::*;
#(
  parameter int NARROW_MAX   = 1,
  parameter int LOCK_PERIODS = 4,
  localparam int WW = $clog2(NARROW_MAX + 2),
  localparam int CW = $clog2(LOCK_PERIODS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  pfdState_t     state,
  input  logic [WW-1:0] errWidth,
  output pfdStrobe_t    strobe,
  output logic          lockOut
);
  localparam logic [WW-1:0] NARROW_LIM = WW'(NARROW_MAX);
  localparam logic [CW-1:0] LOCK_LIM   = CW'(LOCK_PERIODS);

  logic periodDone, narrowDone, pulseWide;
  logic [CW-1:0] lockCnt;

  assign periodDone = state.upSet & state.dnSet;
  assign narrowDone = periodDone && (errWidth <= NARROW_LIM);
  assign pulseWide  = (state.upSet ^ state.dnSet) && (errWidth >= NARROW_LIM);

  assign strobe.clrPair   = periodDone;
  assign strobe.holdWidth = 1'b0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockCnt <= '0;
    end else if (pulseWide || (periodDone && !narrowDone)) begin
      lockCnt <= '0;
    end else if (narrowDone && lockCnt != LOCK_LIM) begin
      lockCnt <= lockCnt + 1'b1;
    end
  end

  assign lockOut = (lockCnt == LOCK_LIM);

  a_r9_lock_after_narrow: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockOut) |-> $past(narrowDone));
  a_r10_lock_drop: assert property (@(posedge clk) disable iff (!rstN)
    (lockOut && pulseWide) |=> !lockOut);
endmodule

// File: rtl/pfd_top.sv
module pfd_top
  import pfd_pkg::*;
#(
  parameter int NARROW_MAX   = 1,
  parameter int LOCK_PERIODS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic refIn,
  input  logic fbIn,
  input  logic polSwap,
  output logic padDriveHigh,
  output logic padDriveLow,
  output logic lockFlag
);
  localparam int WW = $clog2(NARROW_MAX + 2);

  pfdStrobe_t    strobe;
  pfdState_t     state;
  logic [WW-1:0] errWidth;

  pfd_datapath #(.NARROW_MAX(NARROW_MAX)) uDatapath (
    .clk(clk), .rstN(rstN), .refIn(refIn), .fbIn(fbIn), .polSwap(polSwap),
    .strobe(strobe), .state(state), .errWidth(errWidth),
    .driveHigh(padDriveHigh), .driveLow(padDriveLow)
  );

  pfd_control #(.NARROW_MAX(NARROW_MAX), .LOCK_PERIODS(LOCK_PERIODS)) uControl (
    .clk(clk), .rstN(rstN), .state(state), .errWidth(errWidth),
    .strobe(strobe), .lockOut(lockFlag)
  );

  a_r7_single_drive: assert property (@(posedge clk) disable iff (!rstN)
    !(padDriveHigh && padDriveLow));
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!padDriveHigh && !padDriveLow && !lockFlag));
endmodule

// File: tb/sim_pfd_top.sv
`timescale 1ns/1ps
module sim_pfd_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refIn = 1'b0, fbIn = 1'b0, polSwap = 1'b0;
  logic padDriveHigh, padDriveLow, lockFlag;
  int nChecks = 0, nFails = 0;
  int lockRun = 0;

  always #2 clk = ~clk;

  pfd_top u0 (.clk(clk), .rstN(rstN), .refIn(refIn), .fbIn(fbIn), .polSwap(polSwap),
              .padDriveHigh(padDriveHigh), .padDriveLow(padDriveLow), .lockFlag(lockFlag));

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // One comparison: leading pulse, lagging pulse d clocks later (d<0: fb leads).
  // holdLen: how many clocks each pulse stays high.
  task automatic runPair(input int d, input bit pol, input int holdLen);
    int tRef, tFb, hi, lo, both, mag;
    bit narrow;
    polSwap = pol;
    mag = (d < 0) ? -d : d;
    tRef = (d >= 0) ? 0 : mag;
    tFb  = (d >= 0) ? mag : 0;
    hi = 0; lo = 0; both = 0;
    for (int i = 0; i < mag + holdLen + 8; i++) begin
      @(negedge clk);
      if (i > 0) begin
        hi += padDriveHigh;
        lo += padDriveLow;
        both += (padDriveHigh && padDriveLow);
      end
      refIn = (i >= tRef) && (i < tRef + holdLen);
      fbIn  = (i >= tFb) && (i < tFb + holdLen);
    end
    if (d == 0) begin
      check("R6 same-clock high", hi, 0);
      check("R6 same-clock low", lo, 0);
    end else if ((d > 0) ^ pol) begin
      check(pol ? "R5 swapped high width" : "R3 high width", hi, mag);
      check(pol ? "R5 swapped low idle" : "R3 low idle", lo, 0);
    end else begin
      check(pol ? "R5 swapped low width" : "R4 low width", lo, mag);
      check(pol ? "R5 swapped high idle" : "R4 high idle", hi, 0);
    end
    check("R7 never both", both, 0);
    narrow = (mag <= 1);
    lockRun = narrow ? ((lockRun < 4) ? lockRun + 1 : 4) : 0;
    check("R9 lock after period", lockFlag, (lockRun >= 4) ? 1 : 0);
  endtask

  initial begin
    #(200000 * 4);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset high", padDriveHigh, 0);
    check("R1 reset low", padDriveLow, 0);
    check("R1 reset lock", lockFlag, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 post-reset high", padDriveHigh, 0);
    check("R1 post-reset lock", lockFlag, 0);

    // Sweep of edge gaps for both polarities, lock tracked arithmetically
    for (int p = 0; p < 2; p++)
      for (int d = -7; d <= 7; d++)
        runPair(d, p[0], 1);

    // R2: long-held inputs count as one edge each
    for (int d = -4; d <= 4; d++) runPair(d, 1'b0, 6);

    // R9: lock sequence through narrow periods, checked each period
    for (int k = 0; k < 6; k++) runPair((k % 3) - 1, k[0], 1);
    check("R9 locked", lockFlag, 1);

    // R10: wide pulse drops lock on the exact clock
    polSwap = 1'b0;
    @(negedge clk); refIn = 1'b1;
    @(negedge clk); refIn = 1'b0;
    check("R10 lock kept 1st clock", lockFlag, 1);
    @(negedge clk);
    check("R10 lock kept 2nd clock", lockFlag, 1);
    @(negedge clk);
    check("R10 lock dropped", lockFlag, 0);
    @(negedge clk); fbIn = 1'b1;
    @(negedge clk); fbIn = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 stays unlocked", lockFlag, 0);
    lockRun = 0;

    // R8: repeated fb edges with no ref edge keep low drive continuous
    begin
      int held = 0;
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        if (i > 0) held += padDriveLow;
        fbIn = (i % 4) == 0;
      end
      check("R8 continuous low", held, 15);
      @(negedge clk); fbIn = 1'b0; refIn = 1'b1;
      @(negedge clk); refIn = 1'b0;
      repeat (3) @(negedge clk);
      check("R8 released low", padDriveLow, 0);
      check("R8 released high", padDriveHigh, 0);
    end

    // R1: reset mid-operation clears everything
    @(negedge clk); refIn = 1'b1;
    @(negedge clk); refIn = 1'b0; rstN = 1'b0;
    @(negedge clk);
    check("R1 reset clears high", padDriveHigh, 0);
    rstN = 1'b1;
    summary();
  end
endmodule